// File: doc/BRIEF.md
# One-Wire Byte Transfer Unit

This block moves whole bytes over a one-wire bus by driving a separate bit-slot engine. A byte enters on a valid/ready port together with two options: a read flag, which replaces the data with all ones so the bus is released in every slot, and a pull-up request. The unit then asks the bit engine for eight slots in a row. It sends the byte least significant bit first and shifts each sampled bus bit into the top of a working register. When the eighth slot ends, the register holds the received byte in its normal bit order.

Write and read use the same full-duplex shift. A plain write returns whatever the bus carried: the transmitted value AND-ed with the bits a device pulled low. A read is a write of all ones. The input port has back-pressure: `in_ready` is high only while the unit is idle. A byte is taken on any rising edge where `in_valid` and `in_ready` are both high. While a transfer runs, `in_valid` is ignored. The completion side has no back-pressure. `byte_done` is a one-cycle strobe, and the consumer must take `rx_byte` in that cycle.

For parasite-powered devices, the unit can switch on a strong pull-up right after the last slot of a byte. The pull-up then stays on until `spu_off` is pulsed or the next byte is accepted.

Top module: `ow_byte_xfer`

## Requirements
- R1: After reset, `in_ready` is 1 and `bit_req`, `byte_done` and `spu_en` are 0.
- R2: A byte is accepted only on an edge where `in_valid` and `in_ready` are both 1. From that edge until `byte_done`, `in_ready` is 0 and `in_valid` has no effect on the transfer.
- R3: Slot k (k = 0..7) transmits bit k of the accepted byte on `bit_tx`, lowest bit first. `bit_tx` stays stable while `bit_req` is high and `bit_done` has not yet arrived.
- R4: On each edge where `bit_req` and `bit_done` are both 1, the working register shifts right and `bit_rx` enters at bit 7. As a result, `rx_byte[k]` equals the bit sampled in slot k.
- R5: Exactly eight `bit_req`/`bit_done` completions make up one byte. `byte_done` is 1 for exactly one cycle, the cycle after the eighth completion. `rx_byte` is valid in that cycle, and `in_ready` is 1 in that same cycle.
- R6: With `in_rd` = 1, every slot transmits 1 and the value on `in_data` is ignored.
- R7: With `in_spu` = 1, `spu_en` rises in the `byte_done` cycle and never during the byte's first seven slots or during its eighth slot.
- R8: Once on, `spu_en` stays 1 until `spu_off` is sampled high. `spu_en` is 0 on the cycle after any edge where `spu_off` is 1, and `spu_off` wins over a same-edge turn-on.
- R9: Accepting a new byte turns `spu_en` off from the following cycle.
- R10: With `in_spu` = 0, `spu_en` stays 0 through the whole byte and in its `byte_done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte request valid |
| in_ready | output | 1 | Unit idle, byte can be accepted |
| in_data | input | 8 | Byte to transmit, LSB first |
| in_rd | input | 1 | Read: transmit all ones instead of `in_data` |
| in_spu | input | 1 | Turn on strong pull-up after the last slot |
| bit_req | output | 1 | Slot request to the bit engine, held until `bit_done` |
| bit_tx | output | 1 | Bit to send in the current slot |
| bit_done | input | 1 | Bit engine: slot finished, `bit_rx` valid |
| bit_rx | input | 1 | Bus level sampled by the bit engine |
| byte_done | output | 1 | One-cycle strobe: byte finished |
| rx_byte | output | 8 | Received byte, valid while `byte_done` is high |
| spu_off | input | 1 | Turn strong pull-up off |
| spu_en | output | 1 | Strong pull-up drive enable |

## Verification
`bit_req` goes high in the cycle after the accepting edge. The bench's bit engine reads `bit_tx`, records it, and raises `bit_done` on falling edges, after a chosen number of slot cycles. The bench records `spu_en` at every slot completion and expects 0 at each one. `byte_done`, `rx_byte`, `in_ready` and a requested `spu_en` are all due one cycle after the eighth completion edge, so the bench polls `byte_done` on falling edges and checks the other outputs in the same sample. A pulse on `spu_off`, or the acceptance of a byte, clears `spu_en` one edge later, and the bench samples at the next falling edge.

// File: rtl/ow_xfer_pkg.sv
package ow_xfer_pkg;
  typedef enum logic [0:0] {
    XS_IDLE = 1'b0,
    XS_SLOT = 1'b1
  } xfer_state_e;
endpackage

// File: rtl/ow_xfer_ctrl.sv
// Slot sequencer: counts bit-engine completions and frames one byte.
module ow_xfer_ctrl
  import ow_xfer_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic bit_done,
  output logic in_ready,
  output logic accept,
  output logic bit_req,
  output logic slot_fire,
  output logic last_fire,
  output logic byte_done
);
  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

  xfer_state_e       state_q;
  logic [CNT_W-1:0]  slot_q;
  logic              done_q;

  assign in_ready  = (state_q == XS_IDLE);
  assign bit_req   = (state_q == XS_SLOT);
  assign accept    = in_valid && in_ready;
  assign slot_fire = bit_req && bit_done;
  assign last_fire = slot_fire && (slot_q == LAST_IDX);
  assign byte_done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      slot_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_fire;
      unique case (state_q)
        XS_IDLE: begin
          if (accept) begin
            state_q <= XS_SLOT;
            slot_q  <= '0;
          end
        end
        XS_SLOT: begin
          if (last_fire) begin
            state_q <= XS_IDLE;
            slot_q  <= '0;
          end else if (slot_fire) begin
            slot_q <= slot_q + 1'b1;
          end
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ow_xfer_shreg.sv
// Full-duplex shift register: LSB leaves on the bus, sampled bit enters at top.
module ow_xfer_shreg #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_rd,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              shift,
  input  logic              rx_bit,
  output logic              tx_bit,
  output logic [BYTE_W-1:0] word
);
  localparam logic [BYTE_W-1:0] ALL_ONES = {BYTE_W{1'b1}};

  logic [BYTE_W-1:0] q;
  logic [BYTE_W-1:0] next_load;

  // Read is a write of all ones: the bus is released in every slot.
  assign next_load = load_rd ? ALL_ONES : load_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= next_load;
    end else if (shift) begin
      q <= {rx_bit, q[BYTE_W-1:1]};
    end
  end

  assign tx_bit = q[0];
  assign word   = q;
endmodule

// File: rtl/ow_xfer_pullup.sv
// Strong pull-up control: armed per byte, fires after the final slot only.
module ow_xfer_pullup (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic want,
  input  logic last_fire,
  input  logic off,
  output logic spu_en
);
  logic armed_q;
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (accept) begin
      armed_q <= want;
    end else if (last_fire) begin
      armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (off || accept) begin
      en_q <= 1'b0;
    end else if (last_fire && armed_q) begin
      en_q <= 1'b1;
    end
  end

  assign spu_en = en_q;
endmodule

// File: rtl/ow_byte_xfer.sv
module ow_byte_xfer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_rd,
  input  logic              in_spu,
  output logic              bit_req,
  output logic              bit_tx,
  input  logic              bit_done,
  input  logic              bit_rx,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  input  logic              spu_off,
  output logic              spu_en
);
  logic accept;
  logic slot_fire;
  logic last_fire;

  ow_xfer_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .bit_done  (bit_done),
    .in_ready  (in_ready),
    .accept    (accept),
    .bit_req   (bit_req),
    .slot_fire (slot_fire),
    .last_fire (last_fire),
    .byte_done (byte_done)
  );

  ow_xfer_shreg #(.BYTE_W(BYTE_W)) u_shreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_rd  (in_rd),
    .load_val (in_data),
    .shift    (slot_fire),
    .rx_bit   (bit_rx),
    .tx_bit   (bit_tx),
    .word     (rx_byte)
  );

  ow_xfer_pullup u_pullup (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .want      (in_spu),
    .last_fire (last_fire),
    .off       (spu_off),
    .spu_en    (spu_en)
  );
endmodule

// File: rtl/ow_xfer_chk.sv
module ow_xfer_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [BYTE_W-1:0] in_data,
  input logic              in_rd,
  input logic              in_spu,
  input logic              bit_req,
  input logic              bit_tx,
  input logic              bit_done,
  input logic              bit_rx,
  input logic              byte_done,
  input logic [BYTE_W-1:0] rx_byte,
  input logic              spu_off,
  input logic              spu_en
);
  localparam int SC_W = $clog2(BYTE_W + 1) + 1;

  // Completions seen since the last accepted byte.
  logic [SC_W-1:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (in_valid && in_ready) seen_q <= '0;
    else if (bit_req && bit_done) seen_q <= seen_q + 1'b1;
  end

  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req |-> !in_ready);
  a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> bit_req);
  a_r3_tx_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req && !bit_done) |=> $stable(bit_tx));
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);
  a_r5_eight_slots: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> (seen_q == SC_W'(BYTE_W)));
  a_r5_ready_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> in_ready);
  a_r7_spu_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spu_en) |-> byte_done);
  a_r8_spu_off: assert property (@(posedge clk) disable iff (!rst_n)
    spu_off |=> !spu_en);
  a_r9_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !spu_en);
endmodule

bind ow_byte_xfer ow_xfer_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/sim_ow_byte_xfer.sv
`timescale 1ns/1ps
module sim_ow_byte_xfer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_rd = 1'b0;
  logic       in_spu = 1'b0;
  logic       bit_req;
  logic       bit_tx;
  logic       bit_done = 1'b0;
  logic       bit_rx = 1'b0;
  logic       byte_done;
  logic [7:0] rx_byte;
  logic       spu_off = 1'b0;
  logic       spu_en;

  always #2.5 clk = ~clk;

  ow_byte_xfer #(.BYTE_W(8)) u0 (.*);

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Bit-engine model state
  int         eng_lat = 1;
  int         eng_wait = 0;
  int         eng_slot = 0;
  logic [7:0] eng_slave = 8'hFF;
  logic [7:0] tx_log;
  logic [7:0] spu_log;
  logic       tx_start;
  logic       tx_moved;

  // Vector: [17]=rd [16]=spu [15:8]=data [7:0]=slave pull-down mask (1 = release)
  localparam int NVEC = 8;
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'hA5, 8'hFF},
    {1'b0, 1'b0, 8'h3C, 8'hF0},
    {1'b1, 1'b0, 8'h00, 8'h28},
    {1'b1, 1'b1, 8'h12, 8'hC3},
    {1'b0, 1'b1, 8'hFF, 8'h5A},
    {1'b0, 1'b0, 8'h01, 8'hFF},
    {1'b1, 1'b0, 8'h55, 8'h80},
    {1'b0, 1'b0, 8'h80, 8'h7F}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bit engine: acts on falling edges, slot lasts eng_lat+1 cycles.
  initial begin
    forever begin
      @(negedge clk);
      if (bit_done) begin
        bit_done = 1'b0;
      end else if (bit_req) begin
        if (eng_wait == 0) tx_start = bit_tx;
        if (bit_tx != tx_start) tx_moved = 1'b1;
        if (eng_wait >= eng_lat) begin
          if (eng_slot < 8) begin
            tx_log[eng_slot]  = bit_tx;
            spu_log[eng_slot] = spu_en;
          end
          bit_rx   = bit_tx & eng_slave[eng_slot % 8];
          eng_slot = eng_slot + 1;
          eng_wait = 0;
          bit_done = 1'b1;
        end else begin
          eng_wait = eng_wait + 1;
        end
      end
    end
  end

  task automatic start_byte(input bit rd, input bit spu, input logic [7:0] data,
                            input logic [7:0] slave, input int lat);
    @(negedge clk);
    eng_lat = lat; eng_wait = 0; eng_slot = 0; eng_slave = slave;
    tx_log = 8'h00; spu_log = 8'h00; tx_moved = 1'b0;
    in_valid = 1'b1; in_data = data; in_rd = rd; in_spu = spu;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int n = 0; n < 400 && !byte_done; n++) @(negedge clk);
  endtask

  task automatic check_byte(input bit rd, input bit spu, input logic [7:0] data,
                            input logic [7:0] slave);
    logic [7:0] exp_tx;
    exp_tx = rd ? 8'hFF : data;
    chk(byte_done === 1'b1, "R5 byte_done", int'(byte_done), 1);
    chk(eng_slot == 8, "R5 slot count", eng_slot, 8);
    chk(tx_log == exp_tx, rd ? "R6 read sends ones" : "R3 tx order", tx_log, exp_tx);
    chk(!tx_moved, "R3 tx stable in slot", int'(tx_moved), 0);
    chk(rx_byte == (exp_tx & slave), "R4 rx byte", rx_byte, exp_tx & slave);
    chk(in_ready === 1'b1, "R5 ready with done", int'(in_ready), 1);
    chk(spu_log == 8'h00, "R7 no pull-up during slots", spu_log, 0);
    chk(spu_en === spu, spu ? "R7 pull-up at done" : "R10 no pull-up", int'(spu_en), int'(spu));
    @(negedge clk);
    chk(byte_done === 1'b0, "R5 done one cycle", int'(byte_done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(in_ready === 1'b1, "R1 ready", int'(in_ready), 1);
    chk(bit_req === 1'b0, "R1 req", int'(bit_req), 0);
    chk(byte_done === 1'b0, "R1 done", int'(byte_done), 0);
    chk(spu_en === 1'b0, "R1 spu", int'(spu_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bit_req === 1'b0 && in_ready === 1'b1, "R1 idle after reset", int'(bit_req), 0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      start_byte(VEC[i][17], VEC[i][16], VEC[i][15:8], VEC[i][7:0], i % 3);
      chk(spu_en === 1'b0, "R9 accept clears", int'(spu_en), 0);
      wait_done();
      check_byte(VEC[i][17], VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
    end

    // R2: in_valid ignored while busy
    start_byte(1'b0, 1'b0, 8'hC6, 8'hFF, 3);
    repeat (4) @(negedge clk);
    in_valid = 1'b1; in_data = 8'h39; in_rd = 1'b1; in_spu = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b0, "R2 not ready when busy", int'(in_ready), 0);
    repeat (6) @(negedge clk);
    in_valid = 1'b0;
    wait_done();
    check_byte(1'b0, 1'b0, 8'hC6, 8'hFF);

    // R8: pull-up holds until spu_off
    start_byte(1'b0, 1'b1, 8'h6E, 8'hFF, 1);
    wait_done();
    check_byte(1'b0, 1'b1, 8'h6E, 8'hFF);
    repeat (10) @(negedge clk);
    chk(spu_en === 1'b1, "R8 pull-up held", int'(spu_en), 1);
    spu_off = 1'b1;
    @(negedge clk);
    spu_off = 1'b0;
    chk(spu_en === 1'b0, "R8 pull-up off", int'(spu_en), 0);

    // R8: spu_off held during the last slot beats turn-on
    start_byte(1'b0, 1'b1, 8'h0F, 8'hFF, 2);
    spu_off = 1'b1;
    wait_done();
    chk(spu_en === 1'b0, "R8 off wins", int'(spu_en), 0);
    spu_off = 1'b0;
    @(negedge clk);
    chk(spu_en === 1'b0, "R8 stays off", int'(spu_en), 0);

    // R9: new byte clears a held pull-up
    start_byte(1'b1, 1'b1, 8'h00, 8'h96, 1);
    wait_done();
    check_byte(1'b1, 1'b1, 8'h00, 8'h96);
    repeat (3) @(negedge clk);
    start_byte(1'b0, 1'b0, 8'hE7, 8'hFF, 0);
    chk(spu_en === 1'b0, "R9 accept clears held", int'(spu_en), 0);
    wait_done();
    check_byte(1'b0, 1'b0, 8'hE7, 8'hFF);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule